// File: doc/BRIEF.md
# Word-Granular Hardware Stack Engine

This block keeps a downward-growing stack of 16-bit words in a small internal memory and owns the byte-addressed stack pointer that indexes it. A client raises a push request with a data word, or a pop request, for one cycle. A push first moves the pointer down by two bytes and then stores the word at the new address. A pop first reads the word the pointer addresses and then moves the pointer up by two. The pointer therefore always names the most recently pushed word. The stack is empty when the pointer equals its base address.

The legal region runs from a lower-limit address up to, but not including, the base address. A push that would take the pointer below the limit is refused and sets a sticky overflow flag. A pop on an empty stack is refused and sets a sticky underflow flag. A push and a pop in the same cycle is a client error: the pop is served, the push is dropped, and a one-cycle error pulse follows. Only whole words move; there is no byte access.

Top module: `wstk_engine`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), sp equals BASE_ADDR, empty is 1, full is 0, overflow, underflow, collide_err and pop_valid are 0.
- R2: An accepted push (push_req=1, pop_req=0, full=0) makes sp equal its old value minus 2 after the clock edge, and stores push_data at that new address.
- R3: A push while full=1 (sp equals LIMIT_ADDR) leaves sp and the stored contents unchanged and sets overflow to 1 after the edge.
- R4: An accepted pop (pop_req=1, empty=0) raises pop_valid for exactly the following cycle with pop_data equal to the word at the old sp, and makes sp equal its old value plus 2.
- R5: A pop while empty=1 leaves sp unchanged, keeps pop_valid at 0 in the next cycle and sets underflow to 1.
- R6: Words come back from pops in the reverse of the order in which they were pushed (last in, first out).
- R7: push_req and pop_req both high in one cycle serves the pop only, drops the push data, and raises collide_err for exactly the next cycle.
- R8: sp is always even and lies between LIMIT_ADDR and BASE_ADDR inclusive; empty is 1 exactly when sp equals BASE_ADDR and full is 1 exactly when sp equals LIMIT_ADDR.
- R9: overflow and underflow, once set, stay at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Push one word this cycle |
| push_data | input | DATA_W (16) | Word to push |
| pop_req | input | 1 | Pop one word this cycle |
| pop_data | output | DATA_W (16) | Word returned by the last accepted pop |
| pop_valid | output | 1 | pop_data is fresh this cycle |
| sp | output | ADDR_W (8) | Byte address of the top-of-stack word |
| empty | output | 1 | Stack holds no word |
| full | output | 1 | Stack region is used up |
| overflow | output | 1 | Sticky: a push was refused at the limit |
| underflow | output | 1 | Sticky: a pop was refused on an empty stack |
| collide_err | output | 1 | One-cycle pulse after push and pop arrived together |

## Verification
The hardest state to reach is the stack filled to the limit, followed by a refused push and a pop that must still return the last word accepted, not the refused one. The bench fills every slot with distinct words from its driver task, issues one more push, and then drains the whole stack through the scoreboard. A similar case is the collision: a push and a pop arrive in the same cycle on a non-empty stack, and a follow-up pop on the now-empty stack shows that the dropped word never reached memory.

// File: rtl/wstk_pkg.sv
// Package: shared types for the word stack engine.
// Assumes: requests are sampled once per clock edge.
package wstk_pkg;

    // Request class decoded from the two request lines.
    typedef enum logic [1:0] {
        REQ_NONE = 2'b00,
        REQ_PUSH = 2'b01,
        REQ_POP  = 2'b10,
        REQ_BOTH = 2'b11
    } stk_req_e;

    // Outcome of one cycle, as decided by the pointer unit.
    typedef struct packed {
        logic push_go;    // push accepted, memory written
        logic pop_go;     // pop accepted, memory read
        logic push_deny;  // push refused at the limit
        logic pop_deny;   // pop refused on empty stack
        logic clash;      // push and pop arrived together
    } stk_verdict_t;

    // Map request lines onto the enum.
    function automatic stk_req_e classify(input logic push_r, input logic pop_r);
        return stk_req_e'({pop_r, push_r});
    endfunction

endpackage

// File: rtl/wstk_ptr.sv
// Module: wstk_ptr
// Holds the byte-addressed stack pointer, decides whether each request is
// accepted, and produces the word indices for the memory.
// Assumes: BASE_ADDR and LIMIT_ADDR are even, LIMIT_ADDR < BASE_ADDR, and
// the span between them is a power-of-two number of words.
module wstk_ptr
    import wstk_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BASE_ADDR  = 128,
    parameter int LIMIT_ADDR = 96,
    parameter int IDX_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    output logic [ADDR_W-1:0] sp,
    output logic              empty,
    output logic              full,
    output stk_verdict_t      verdict,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  rd_idx
);

    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LIMIT_ADDR);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(2);

    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] sp_dn;
    logic [ADDR_W-1:0] sp_up;
    stk_req_e          req;

    assign sp    = sp_q;
    assign empty = (sp_q == BASE_A);
    assign full  = (sp_q == LIMIT_A);
    assign sp_dn = sp_q - STEP;
    assign sp_up = sp_q + STEP;

    // Word indices relative to the limit: pre-decremented for write, current for read.
    assign wr_idx = IDX_W'((sp_dn - LIMIT_A) >> 1);
    assign rd_idx = IDX_W'((sp_q - LIMIT_A) >> 1);

    // Decide this cycle's outcome; pop wins over push.
    always_comb begin
        req     = classify(push_req, pop_req);
        verdict = '0;
        unique case (req)
            REQ_NONE: ;
            REQ_PUSH: begin
                verdict.push_go   = !full;
                verdict.push_deny = full;
            end
            REQ_POP: begin
                verdict.pop_go   = !empty;
                verdict.pop_deny = empty;
            end
            REQ_BOTH: begin
                verdict.pop_go   = !empty;
                verdict.pop_deny = empty;
                verdict.clash    = 1'b1;
            end
        endcase
    end

    // Move the pointer after an accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= BASE_A;
        end else if (verdict.pop_go) begin
            sp_q <= sp_up;
        end else if (verdict.push_go) begin
            sp_q <= sp_dn;
        end
    end

endmodule

// File: rtl/wstk_mem.sv
// Module: wstk_mem
// Word storage for the stack region, one write port and one registered
// read port. Contents are not reset.
// Assumes: read and write are never enabled in the same cycle.
module wstk_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Store a word at the write index.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[widx] <= wdata;
        end
    end

    // Capture the word at the read index; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[ridx];
        end
    end

endmodule

// File: rtl/wstk_flags.sv
// Module: wstk_flags
// Turns the per-cycle verdict into the sticky bound flags, the collision
// pulse and the read-valid strobe.
// Assumes: verdict bits are settled before the clock edge.
module wstk_flags
    import wstk_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  stk_verdict_t verdict,
    output logic         overflow,
    output logic         underflow,
    output logic         collide_err,
    output logic         pop_valid
);

    // Sticky overflow: set on a refused push, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 overflow <= 1'b0;
        else if (verdict.push_deny) overflow <= 1'b1;
    end

    // Sticky underflow: set on a refused pop, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                underflow <= 1'b0;
        else if (verdict.pop_deny) underflow <= 1'b1;
    end

    // One-cycle pulses for the clash error and fresh read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collide_err <= 1'b0;
            pop_valid   <= 1'b0;
        end else begin
            collide_err <= verdict.clash;
            pop_valid   <= verdict.pop_go;
        end
    end

endmodule

// File: rtl/wstk_engine.sv
// Module: wstk_engine (top)
// Downward-growing word stack: push pre-decrements then writes, pop reads
// then post-increments, with limit and base checks.
// Assumes: one request line per cycle in normal use; both together is an
// error that serves the pop only.
module wstk_engine
    import wstk_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int BASE_ADDR  = 128,
    parameter int LIMIT_ADDR = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [ADDR_W-1:0] sp,
    output logic              empty,
    output logic              full,
    output logic              overflow,
    output logic              underflow,
    output logic              collide_err
);

    localparam int DEPTH = (BASE_ADDR - LIMIT_ADDR) / 2;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stk_verdict_t     verdict;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    wstk_ptr #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .LIMIT_ADDR(LIMIT_ADDR),
        .IDX_W     (IDX_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_req(push_req),
        .pop_req (pop_req),
        .sp      (sp),
        .empty   (empty),
        .full    (full),
        .verdict (verdict),
        .wr_idx  (wr_idx),
        .rd_idx  (rd_idx)
    );

    wstk_mem #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (verdict.push_go),
        .widx (wr_idx),
        .wdata(push_data),
        .re   (verdict.pop_go),
        .ridx (rd_idx),
        .rdata(pop_data)
    );

    wstk_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .verdict    (verdict),
        .overflow   (overflow),
        .underflow  (underflow),
        .collide_err(collide_err),
        .pop_valid  (pop_valid)
    );

endmodule

// File: rtl/wstk_checker.sv
// Module: wstk_checker
// Port-level properties of the stack engine, bound onto every instance.
module wstk_checker #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int BASE_ADDR  = 128,
    parameter int LIMIT_ADDR = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic [DATA_W-1:0] push_data,
    input logic              pop_req,
    input logic [DATA_W-1:0] pop_data,
    input logic              pop_valid,
    input logic [ADDR_W-1:0] sp,
    input logic              empty,
    input logic              full,
    input logic              overflow,
    input logic              underflow,
    input logic              collide_err
);

    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LIMIT_ADDR);

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !full) |=> (sp == $past(sp) - ADDR_W'(2)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && full) |=> ($stable(sp) && overflow));

    assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !empty) |=> (pop_valid && sp == $past(sp) + ADDR_W'(2)));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> ($stable(sp) && underflow && !pop_valid));

    assert_clash_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req) |=> collide_err);

    assert_sp_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp[0] && sp >= LIMIT_A && sp <= BASE_A));

    assert_empty_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (sp == BASE_A)) && (full == (sp == LIMIT_A)));

    assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_sticky_unf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

endmodule

bind wstk_engine wstk_checker #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .LIMIT_ADDR(LIMIT_ADDR)
) u_chk (.*);

// File: tb/wstk_engine_test.sv
// Scoreboard bench: driver tasks model the stack and queue expected pop
// results; a monitor compares them when pop_valid appears.
module wstk_engine_test;

    localparam int BASE  = 128;
    localparam int LIMIT = 96;
    localparam int SLOTS = (BASE - LIMIT) / 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_req;
    logic [15:0] push_data;
    logic        pop_req;
    logic [15:0] pop_data;
    logic        pop_valid;
    logic [7:0]  sp;
    logic        empty, full, overflow, underflow, collide_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] model_stk[$];
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    wstk_engine #(.BASE_ADDR(BASE), .LIMIT_ADDR(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .sp(sp), .empty(empty), .full(full), .overflow(overflow),
        .underflow(underflow), .collide_err(collide_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // All driver tasks start and end at a falling edge.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            push_req = 1'b0; pop_req = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_push(input logic [15:0] d);
        push_req = 1'b1; pop_req = 1'b0; push_data = d;
        if (model_stk.size() < SLOTS) model_stk.push_back(d);
        @(negedge clk);
        push_req = 1'b0;
    endtask

    task automatic do_pop();
        pop_req = 1'b1; push_req = 1'b0;
        if (model_stk.size() > 0) exp_q.push_back(model_stk.pop_back());
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic do_both(input logic [15:0] d);
        push_req = 1'b1; pop_req = 1'b1; push_data = d;
        if (model_stk.size() > 0) exp_q.push_back(model_stk.pop_back());
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
    endtask

    // Monitor: every fresh read must match the oldest expected word (R4, R6).
    always @(negedge clk) begin
        if (rst_n && pop_valid) begin
            if (exp_q.size() == 0) check("R4 unexpected pop_valid", 32'(pop_valid), 32'd0);
            else                   check("R6 pop order", 32'(pop_data), 32'(exp_q.pop_front()));
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; push_req = 1'b0; pop_req = 1'b0; push_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 sp", 32'(sp), BASE);
        check("R1 empty", 32'(empty), 1);
        check("R1 flags", 32'({full, overflow, underflow, collide_err, pop_valid}), 0);

        // R2 push steps and LIFO of three words
        do_push(16'hA11A);
        check("R2 sp after push", 32'(sp), BASE - 2);
        do_push(16'hB22B);
        do_push(16'hC33C);
        check("R2 sp after three", 32'(sp), BASE - 6);
        do_pop();
        check("R4 pop_valid", 32'(pop_valid), 1);
        check("R4 sp after pop", 32'(sp), BASE - 4);
        do_pop();
        do_pop();
        idle(1);
        check("R4 pop_valid falls", 32'(pop_valid), 0);
        check("R8 empty after drain", 32'(empty), 1);

        // R5 pop on empty stack
        do_pop();
        check("R5 sp kept", 32'(sp), BASE);
        check("R5 no pop_valid", 32'(pop_valid), 0);
        check("R5 underflow", 32'(underflow), 1);
        idle(2);
        check("R9 underflow sticky", 32'(underflow), 1);

        // Interleaved pattern
        do_push(16'h0101); do_push(16'h0202); do_pop();
        do_push(16'h0303); do_pop(); do_pop();
        idle(1);
        check("R6 interleave empty", 32'(sp), BASE);

        // R3 fill to the limit, refused push, then drain
        for (int i = 0; i < SLOTS; i++) do_push(16'h5000 + 16'(i));
        check("R8 full", 32'(full), 1);
        check("R8 sp at limit", 32'(sp), LIMIT);
        check("R3 no overflow yet", 32'(overflow), 0);
        do_push(16'hDEAD);
        check("R3 sp kept", 32'(sp), LIMIT);
        check("R3 overflow", 32'(overflow), 1);
        for (int i = 0; i < SLOTS; i++) do_pop();
        idle(1);
        check("R9 overflow sticky", 32'(overflow), 1);
        check("R2 back to base", 32'(sp), BASE);

        // R7 collision: pop served, push dropped
        do_push(16'h7777);
        do_both(16'h9999);
        check("R7 collide_err", 32'(collide_err), 1);
        check("R7 sp after clash", 32'(sp), BASE);
        idle(1);
        check("R7 pulse ends", 32'(collide_err), 0);
        do_pop();
        check("R7 dropped push not stored", 32'(pop_valid), 0);

        // R1/R9 reset clears sticky flags
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 cleared by reset", 32'({overflow, underflow}), 0);
        check("R1 sp after reset", 32'(sp), BASE);

        idle(2);
        check("R6 scoreboard drained", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule